// File: doc/BRIEF.md
# I2C Target Byte Controller

This block lets a system-clocked host act as an addressed target on a two-wire I2C bus, moving one byte at a time. It oversamples SCL and SDA on the system clock and recognises START and STOP conditions. After a START it collects a 7-bit address and a direction bit and compares the address with the `own_addr` input. On a match it acknowledges, and it then either sends bytes supplied by the host or delivers received bytes to the host. SDA is open-drain: `sda_oe` high pulls the line low, and the line is released at all other times.

Data crosses the host edge as two streams. The transmit stream (`tx_valid`/`tx_ready`/`tx_data`) accepts one byte per bus byte. `tx_ready` is high only while the controller waits for the next byte in transmit mode. A byte offered while `tx_ready` is low is not taken and has no effect, so the host simply holds it. The receive stream (`rx_valid`/`rx_ready`/`rx_data`) holds the last received byte until the host takes it. The bus cannot be held off, because there is no clock stretching. A byte that completes while the previous one is still unread therefore replaces it and raises the overrun flag.

Byte boundaries are reported through six sticky flags in `flags`. Each flag is cleared by pulsing a 1 on the same bit of `flag_clr`, and each can drive `irq` through its bit of `irq_en`.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset the following outputs are all 0: `flags`, `busy`, `bus_active`, `sda_oe`, `tx_ready` and `rx_valid`.
- R2: A START (SDA falls while SCL is high) sets flag bit 0 (start), `bus_active` and `busy`.
- R3: The address is received MSB first as 7 bits, followed by the R/W bit. On a match with `own_addr`, the controller pulls SDA low during the 9th clock, sets flag bit 1 (address match) and clears `busy`. R/W=1 selects transmit and R/W=0 selects receive.
- R4: On an address mismatch the controller does not acknowledge. It then drives nothing and sets no flag until the next START.
- R5: In transmit mode, an accepted byte sets `busy` and is sent MSB first. The first bit appears while SCL is low, and each later bit follows a falling SCL edge. A 0 bit pulls SDA low and a 1 bit releases it.
- R6: `tx_ready` is low while `busy` is high. A byte offered while `tx_ready` is low is discarded and is never sent.
- R7: After the 8th bit the controller releases SDA and samples the acknowledge on the 9th rising SCL edge. It then sets flag bit 2 (transmit done), loads flag bit 4 with the sampled level (1 means NACK) and clears `busy`.
- R8: In receive mode, `busy` rises on the first SCL rising edge. The controller shifts SDA in MSB first on each rising edge. After 8 bits the byte is placed on `rx_data` with `rx_valid` high, flag bit 3 (receive done) is set, and SDA is pulled low during the 9th clock.
- R9: If a received byte completes while `rx_valid` is high and `rx_ready` is low, flag bit 5 (overrun) is set and `rx_data` takes the new byte.
- R10: A STOP (SDA rises while SCL is high) clears `busy` and `bus_active`.
- R11: Flags are sticky. Each flag clears only when a 1 is written to its bit of `flag_clr`, and other bits are unaffected.
- R12: `irq` is high exactly when some flag bit and its `irq_en` bit are both 1.
- R13: `rx_valid` stays high until a cycle in which `rx_ready` is high, and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own 7-bit target address |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte accepted this cycle if valid |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte held |
| rx_ready | input | 1 | Host takes received byte |
| rx_data | output | 8 | Received byte |
| irq_en | input | 6 | Interrupt enable per flag |
| flag_clr | input | 6 | Write-1-to-clear pulses per flag |
| flags | output | 6 | Sticky flags: 0 start, 1 addr match, 2 tx done, 3 rx done, 4 NACK, 5 overrun |
| busy | output | 1 | Byte transfer in progress |
| bus_active | output | 1 | Between START and STOP |
| irq | output | 1 | Interrupt request |

## Verification
The receive overrun is the hardest state to reach. It needs two complete bus bytes while the host side withholds `rx_ready`, so the bench sends a second byte before it pulses `rx_ready`. It then checks that the flag is set and that the new byte replaced the old one. The busy-time discard is the second difficult case. It needs a transmit offer inside the window between byte acceptance and the acknowledge sample. The bench makes that offer a few cycles after loading and checks that only the first byte appears on SDA.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int NFLAG    = 6;
  localparam int F_START  = 0;
  localparam int F_AMATCH = 1;
  localparam int F_TXDONE = 2;
  localparam int F_RXDONE = 3;
  localparam int F_NACK   = 4;
  localparam int F_OVR    = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ACK_PRE, S_ACK_DRV, S_TX_WAIT,
    S_TX_BIT, S_TX_ACKW, S_TX_ACKEND, S_RX_BIT, S_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              sda_oe,
  output logic              busy,
  output logic              bus_active,
  output logic [NFLAG-1:0]  flag_set,
  output logic              nack_upd,
  output logic              nack_val
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int ADDR_W = DATA_W - 1;

  tgt_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sr_q, next_sr;
  logic              mode_tx_q, last_bit;

  assign next_sr  = {sr_q[DATA_W-2:0], sda_s};
  assign last_bit = (cnt_q == CNT_W'(DATA_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      sr_q       <= '0;
      mode_tx_q  <= 1'b0;
      busy       <= 1'b0;
      bus_active <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      flag_set   <= '0;
      nack_upd   <= 1'b0;
      nack_val   <= 1'b0;
    end else begin
      flag_set <= '0;
      nack_upd <= 1'b0;
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (start_det) begin
        state_q           <= S_ADDR;
        cnt_q             <= '0;
        busy              <= 1'b1;
        bus_active        <= 1'b1;
        flag_set[F_START] <= 1'b1;
      end else if (stop_det) begin
        state_q    <= S_IDLE;
        busy       <= 1'b0;
        bus_active <= 1'b0;
      end else begin
        case (state_q)
          S_ADDR: if (scl_rise) begin
            sr_q <= next_sr;
            if (last_bit) begin
              busy <= 1'b0;
              if (next_sr[DATA_W-1 -: ADDR_W] == own_addr) begin
                state_q            <= S_ACK_PRE;
                mode_tx_q          <= sda_s;
                flag_set[F_AMATCH] <= 1'b1;
              end else begin
                state_q <= S_IGNORE;
              end
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          S_ACK_PRE: if (scl_fall) state_q <= S_ACK_DRV;
          S_ACK_DRV: if (scl_fall) begin
            cnt_q   <= '0;
            busy    <= 1'b0;
            state_q <= mode_tx_q ? S_TX_WAIT : S_RX_BIT;
          end
          S_TX_WAIT: if (tx_valid) begin
            sr_q    <= tx_data;
            cnt_q   <= '0;
            busy    <= 1'b1;
            state_q <= S_TX_BIT;
          end
          S_TX_BIT: if (scl_fall) begin
            if (last_bit) state_q <= S_TX_ACKW;
            else begin
              sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
          S_TX_ACKW: if (scl_rise) begin
            nack_upd           <= 1'b1;
            nack_val           <= sda_s;
            flag_set[F_TXDONE] <= 1'b1;
            busy               <= 1'b0;
            state_q            <= S_TX_ACKEND;
          end
          S_TX_ACKEND: if (scl_fall) state_q <= S_TX_WAIT;
          S_RX_BIT: if (scl_rise) begin
            sr_q <= next_sr;
            if (cnt_q == '0) busy <= 1'b1;
            if (last_bit) begin
              rx_data            <= next_sr;
              rx_valid           <= 1'b1;
              flag_set[F_RXDONE] <= 1'b1;
              if (rx_valid && !rx_ready) flag_set[F_OVR] <= 1'b1;
              state_q            <= S_ACK_PRE;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_ready = (state_q == S_TX_WAIT) && !start_det && !stop_det;
  assign sda_oe   = (state_q == S_ACK_DRV) ||
                    ((state_q == S_TX_BIT) && !sr_q[DATA_W-1]);

  // R2: a START leaves the controller busy and the bus marked active
  a_r2_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (busy && bus_active));
  // R10: a STOP returns the controller to quiet
  a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (!busy && !bus_active));
  // R6: the transmit stream never accepts while a byte is in flight
  a_r6_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !busy);
  // R4: an unaddressed transfer raises no flag
  a_r4_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IGNORE && !start_det) |=> (flag_set == '0 && !sda_oe));
endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags
  import i2c_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flag_set,
  input  logic             nack_upd,
  input  logic             nack_val,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic [NFLAG-1:0] irq_en,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else begin
      flags <= (flags & ~flag_clr) | flag_set;
      if (nack_upd) flags[F_NACK] <= nack_val;
    end
  end

  assign irq = |(flags & irq_en);

  // R11: a set flag survives until its clear bit is written
  a_r11_sticky_start: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_START] && !flag_clr[F_START]) |=> flags[F_START]);
  a_r11_sticky_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_OVR] && !flag_clr[F_OVR]) |=> flags[F_OVR]);
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  input  logic [NFLAG-1:0]  irq_en,
  input  logic [NFLAG-1:0]  flag_clr,
  output logic [NFLAG-1:0]  flags,
  output logic              busy,
  output logic              bus_active,
  output logic              irq
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [NFLAG-1:0] flag_set;
  logic nack_upd, nack_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_tgt_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sda_oe(sda_oe), .busy(busy),
    .bus_active(bus_active), .flag_set(flag_set),
    .nack_upd(nack_upd), .nack_val(nack_val));

  i2c_tgt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .nack_upd(nack_upd),
    .nack_val(nack_val), .flag_clr(flag_clr), .irq_en(irq_en),
    .flags(flags), .irq(irq));
endmodule

// File: tb/i2c_tgt_ctrl_tb.sv
module i2c_tgt_ctrl_tb;
  localparam int Q     = 12;
  localparam int LIMIT = 150000;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0] tx_data = '0, rx_data;
  logic [5:0] irq_en = '0, flag_clr = '0, flags;
  logic busy, bus_active, irq;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_tgt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr(OWN), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .irq_en(irq_en), .flag_clr(flag_clr), .flags(flags), .busy(busy),
    .bus_active(bus_active), .irq(irq));

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; waitq(Q);
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    sda_m = 1'b1; waitq(Q);
  endtask

  task automatic wr_bit(input logic b);
    sda_m = b; waitq(Q);
    scl_m = 1'b1; waitq(Q);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic rd_bit(output logic b);
    sda_m = 1'b1; waitq(Q);
    scl_m = 1'b1; waitq(Q/2);
    b = sda_line; waitq(Q/2);
    scl_m = 1'b0; waitq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    rd_bit(ack);
  endtask

  task automatic rd_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rd_bit(v[i]);
  endtask

  task automatic clear_all();
    flag_clr = 6'h3F; @(negedge clk); flag_clr = '0; @(negedge clk);
  endtask

  task automatic offer_tx(input logic [7:0] v);
    tx_data = v; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(flags == 0 && busy == 0 && bus_active == 0, "R1 reset flags/busy", {flags, busy, bus_active}, 0);
    chk(sda_oe == 0 && tx_ready == 0 && rx_valid == 0, "R1 reset streams", {sda_oe, tx_ready, rx_valid}, 0);
  endtask

  task automatic t_receive();
    logic ack;
    clear_all();
    i2c_start();
    chk(flags[0] && busy && bus_active, "R2 start sets flag/busy/active", {flags[0], busy, bus_active}, 7);
    wr_byte({OWN, 1'b0}, ack);
    chk(ack == 0, "R3 address acked", ack, 0);
    chk(flags[1] == 1 && busy == 0, "R3 match flag, busy clear", {flags[1], busy}, 2);
    wr_bit(1'b1);
    chk(busy == 1, "R8 busy on first rx edge", busy, 1);
    for (int i = 6; i >= 0; i--) wr_bit(1'(8'hA5 >> i));
    rd_bit(ack);
    chk(ack == 0, "R8 data byte acked", ack, 0);
    chk(rx_valid && rx_data == 8'hA5, "R8 rx byte", rx_data, 8'hA5);
    chk(flags[3] && !flags[5], "R8 rx done without overrun", {flags[3], flags[5]}, 2);
    chk(busy == 0, "R8 busy cleared after ack", busy, 0);
    wr_byte(8'h3C, ack);
    chk(flags[5] == 1 && rx_data == 8'h3C, "R9 overrun replaces byte", {flags[5], rx_data}, {1'b1, 8'h3C});
    chk(rx_valid == 1, "R13 valid held without ready", rx_valid, 1);
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk);
    chk(rx_valid == 0, "R13 valid drops after ready", rx_valid, 0);
    i2c_stop();
    chk(busy == 0 && bus_active == 0, "R10 stop clears", {busy, bus_active}, 0);
  endtask

  task automatic t_irq();
    irq_en = '0; @(negedge clk);
    chk(irq == 0, "R12 irq masked", irq, 0);
    irq_en = 6'b100000; @(negedge clk);
    chk(irq == 1, "R12 irq on enabled overrun", irq, 1);
    flag_clr = 6'b100000; @(negedge clk); flag_clr = '0; @(negedge clk);
    chk(flags[5] == 0 && flags[3] == 1, "R11 clear only written bit", flags, 6'b001011);
    chk(irq == 0, "R12 irq drops after clear", irq, 0);
    irq_en = '0;
  endtask

  task automatic t_transmit();
    logic ack;
    logic [7:0] got;
    clear_all();
    i2c_start();
    wr_byte({OWN, 1'b1}, ack);
    chk(ack == 0 && flags[1], "R3 read address acked", {ack, flags[1]}, 1);
    chk(tx_ready == 1 && busy == 0, "R5 ready for byte", {tx_ready, busy}, 2);
    offer_tx(8'hC6);
    chk(busy == 1 && tx_ready == 0, "R6 busy after load", {busy, tx_ready}, 2);
    waitq(3);
    offer_tx(8'h11);
    rd_byte(got);
    chk(got == 8'hC6, "R5 R6 byte sent, second discarded", got, 8'hC6);
    chk(sda_oe == 0, "R7 SDA released for ack", sda_oe, 0);
    wr_bit(1'b0);
    chk(flags[2] && !flags[4] && !busy, "R7 ack sampled", {flags[2], flags[4], busy}, 4);
    chk(tx_ready == 1, "R6 ready after ack", tx_ready, 1);
    offer_tx(8'h3B);
    rd_byte(got);
    chk(got == 8'h3B, "R5 second byte", got, 8'h3B);
    wr_bit(1'b1);
    chk(flags[4] == 1, "R7 nack recorded", flags[4], 1);
    i2c_stop();
    chk(busy == 0 && bus_active == 0, "R10 stop after tx", {busy, bus_active}, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    logic seen_oe;
    i2c_start();
    clear_all();
    wr_byte({OWN ^ 7'h01, 1'b0}, ack);
    chk(ack == 1, "R4 no ack on mismatch", ack, 1);
    seen_oe = 1'b0;
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b0; waitq(Q); scl_m = 1'b1;
      for (int k = 0; k < Q; k++) begin @(negedge clk); seen_oe |= sda_oe; end
      scl_m = 1'b0; waitq(Q);
    end
    chk(seen_oe == 0, "R4 never drives after mismatch", seen_oe, 0);
    chk(flags == 0 && rx_valid == 0 && busy == 0, "R4 no flags after mismatch", {flags, rx_valid, busy}, 0);
    i2c_stop();
  endtask

  initial begin
    waitq(4);
    t_reset();
    rst_n = 1'b1;
    waitq(4);
    t_receive();
    t_irq();
    t_transmit();
    t_mismatch();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule